// File: doc/BRIEF.md
# Constellation Phase Sync Controller

This controller closes the carrier-phase loop around a 16-QAM demodulator. The demapper can settle at any of four rotations of the constellation, and three of them yield garbage bytes. The block picks the rotation through a 2-bit quadrant select. While it is unsynchronized, it counts byte strobes from the downstream byte aligner. If a dwell window passes with no sync-marker match, it steps the rotation by 90 degrees.

Once the aligner flags a marker match, the controller declares lock and freezes the rotation. It fires a one-cycle start pulse to the Reed-Solomon decoder on the first byte of the code block. It then counts the code block. When the block ends, it expects the aligner to flag the next marker exactly on the last marker byte. A confirmed marker starts a new block and a new start pulse. A missing marker drops lock and resumes the rotation search from the current quadrant.

Top module: `phase_sync_ctrl`

## Requirements
- R1: After reset, quad_sel is 0, locked is 0 and rs_start is 0.
- R2: While locked is 0, quad_sel increases by one after every DWELL consecutive byte_vld cycles that carry no match. It wraps from 3 to 0.
- R3: A cycle with byte_vld and marker_hit both high while unlocked sets locked from the next cycle on. The partial dwell count is discarded.
- R4: rs_start is high for exactly one cycle. That cycle is the first byte_vld cycle after a confirmed marker, and rs_start is low at every other time.
- R5: While locked is 1, quad_sel does not change. While locked is 1, marker_hit during the BLOCK_LEN code-block bytes has no effect.
- R6: After BLOCK_LEN code-block bytes, the MARKER_LEN-th following byte_vld must carry marker_hit. If it does, the block stays locked and a new code block begins.
- R7: If that byte carries no match, locked is 0 from the next cycle on and quad_sel keeps its value. The next rotation step comes after a full fresh DWELL window.
- R8: Inputs sampled while byte_vld is low, marker_hit included, change neither locked, quad_sel nor any count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Aligner presents a byte this cycle |
| marker_hit | input | 1 | Aligner reports last marker byte on this byte |
| quad_sel | output | 2 | Constellation rotation, 90 degrees per step |
| rs_start | output | 1 | Decoder start pulse on first code-block byte |
| locked | output | 1 | Controller is synchronized |

## Verification
The bench builds the block with DWELL = 8, BLOCK_LEN = 10 and MARKER_LEN = 4. With these sizes, a full quadrant wrap and several complete lock–block–verify rounds fit in a few hundred cycles. The short windows let the bench test a marker hit on the very last dwell byte. They also let it check hits planted inside a code block, a lost marker followed by a fresh dwell, and a re-lock after the rotation has wrapped.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_LOCKED = 2'd1,
        ST_VERIFY = 2'd2
    } psc_state_e;
endpackage

// File: rtl/psc_dwell_timer.sv
module psc_dwell_timer #(
    parameter int DWELL = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic expire
);
    localparam int W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [W-1:0] LAST = W'(DWELL - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } dwell_regs_t;

    dwell_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        expire = step && !clear && (r_q.cnt == LAST);
        if (clear || expire) begin
            r_d.cnt = '0;
        end else if (step) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/psc_frame_counter.sv
module psc_frame_counter #(
    parameter int MAX_COUNT = 255,
    localparam int W = (MAX_COUNT > 1) ? $clog2(MAX_COUNT) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] last_idx,
    output logic         term
);
    typedef struct packed {
        logic [W-1:0] pos;
    } frame_regs_t;

    frame_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        term = step && !clear && (r_q.pos == last_idx);
        if (clear || term) begin
            r_d.pos = '0;
        end else if (step) begin
            r_d.pos = r_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/phase_sync_ctrl.sv
module phase_sync_ctrl #(
    parameter int DWELL      = 1024,
    parameter int BLOCK_LEN  = 255,
    parameter int MARKER_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic       marker_hit,
    output logic [1:0] quad_sel,
    output logic       rs_start,
    output logic       locked
);
    import psc_pkg::*;

    localparam int FMAX = (BLOCK_LEN > MARKER_LEN) ? BLOCK_LEN : MARKER_LEN;
    localparam int FW   = (FMAX > 1) ? $clog2(FMAX) : 1;
    localparam logic [FW-1:0] BLOCK_LAST  = FW'(BLOCK_LEN - 1);
    localparam logic [FW-1:0] MARKER_LAST = FW'(MARKER_LEN - 1);

    typedef struct packed {
        psc_state_e  state;
        logic [1:0]  quad;
        logic        pend;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic          dwell_clear, dwell_step, dwell_expire;
    logic          frame_clear, frame_step, frame_term;
    logic [FW-1:0] frame_last;
    logic          hit_now;

    assign hit_now = byte_vld && marker_hit;

    psc_dwell_timer #(.DWELL(DWELL)) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (dwell_clear),
        .step   (dwell_step),
        .expire (dwell_expire)
    );

    psc_frame_counter #(.MAX_COUNT(FMAX)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_clear),
        .step     (frame_step),
        .last_idx (frame_last),
        .term     (frame_term)
    );

    always_comb begin
        r_d         = r_q;
        dwell_step  = (r_q.state == ST_SEARCH) && byte_vld;
        dwell_clear = (r_q.state != ST_SEARCH) || hit_now;
        frame_step  = (r_q.state != ST_SEARCH) && byte_vld;
        frame_clear = (r_q.state == ST_SEARCH);
        frame_last  = (r_q.state == ST_VERIFY) ? MARKER_LAST : BLOCK_LAST;

        unique case (r_q.state)
            ST_SEARCH: begin
                if (hit_now) begin
                    r_d.state = ST_LOCKED;
                    r_d.pend  = 1'b1;
                end else if (dwell_expire) begin
                    r_d.quad = r_q.quad + 2'd1;
                end
            end
            ST_LOCKED: begin
                if (byte_vld) r_d.pend = 1'b0;
                if (frame_term) r_d.state = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (frame_term) begin
                    if (marker_hit) begin
                        r_d.state = ST_LOCKED;
                        r_d.pend  = 1'b1;
                    end else begin
                        r_d.state = ST_SEARCH;
                    end
                end
            end
            default: r_d.state = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_SEARCH;
            r_q.quad  <= 2'd0;
            r_q.pend  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign quad_sel = r_q.quad;
    assign locked   = (r_q.state != ST_SEARCH);
    assign rs_start = (r_q.state == ST_LOCKED) && r_q.pend && byte_vld;
endmodule

// File: rtl/phase_sync_ctrl_checker.sv
module phase_sync_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic       marker_hit,
    input logic [1:0] quad_sel,
    input logic       rs_start,
    input logic       locked
);
    p_quad_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quad_sel) |-> (quad_sel == $past(quad_sel) + 2'd1))
        else $error("quad_sel moved by more than one step");

    p_lock_after_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(byte_vld && marker_hit))
        else $error("lock without a marker hit");

    p_start_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rs_start |-> (locked && byte_vld))
        else $error("rs_start outside a locked byte");

    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rs_start |=> !rs_start)
        else $error("rs_start longer than one cycle");

    p_quad_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(quad_sel))
        else $error("quad_sel changed while locked");

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> ($stable(quad_sel) && $stable(locked)))
        else $error("state moved without byte_vld");
endmodule

bind phase_sync_ctrl phase_sync_ctrl_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .marker_hit (marker_hit),
    .quad_sel   (quad_sel),
    .rs_start   (rs_start),
    .locked     (locked)
);

// File: tb/phase_sync_ctrl_test.sv
module phase_sync_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DWELL      = 8;
    localparam int BLOCK_LEN  = 10;
    localparam int MARKER_LEN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic       marker_hit = 1'b0;
    logic [1:0] quad_sel;
    logic       rs_start;
    logic       locked;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic       rs;
        logic       lk;
        logic [1:0] qd;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    bit       m_locked = 0;
    bit       m_pend   = 0;
    bit       m_verify = 0;
    int       m_dwell  = 0;
    int       m_pos    = 0;
    bit [1:0] m_quad   = 0;

    phase_sync_ctrl #(
        .DWELL(DWELL), .BLOCK_LEN(BLOCK_LEN), .MARKER_LEN(MARKER_LEN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .marker_hit(marker_hit),
        .quad_sel(quad_sel), .rs_start(rs_start), .locked(locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: applies one byte and pushes the expected outcome.
    task automatic send(input bit hit, input string tag);
        exp_t e;
        e.tag = tag;
        e.rs  = 1'b0;
        if (!m_locked) begin
            if (hit) begin
                m_locked = 1; m_pend = 1; m_verify = 0; m_pos = 0; m_dwell = 0;
            end else begin
                m_dwell++;
                if (m_dwell == DWELL) begin
                    m_quad++;
                    m_dwell = 0;
                end
            end
        end else begin
            e.rs   = m_pend && !m_verify;
            m_pend = 0;
            m_pos++;
            if (!m_verify) begin
                if (m_pos == BLOCK_LEN) begin m_verify = 1; m_pos = 0; end
            end else if (m_pos == MARKER_LEN) begin
                m_pos = 0; m_verify = 0;
                if (hit) m_pend = 1;
                else begin m_locked = 0; m_dwell = 0; end
            end
        end
        e.lk = m_locked;
        e.qd = m_quad;
        exp_q.push_back(e);
        @(posedge clk); #2;
        byte_vld   = 1'b1;
        marker_hit = hit;
    endtask

    task automatic idle(input int n, input bit hit);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            byte_vld   = 1'b0;
            marker_hit = hit;
        end
    endtask

    task automatic block_bytes(input int n, input string tag);
        for (int i = 0; i < n; i++) send(i == 3, tag);
    endtask

    // Monitor: compares each byte's results against the queue.
    initial begin
        forever begin
            logic rs_seen;
            @(negedge clk);
            if (byte_vld) begin
                exp_t e;
                rs_seen = rs_start;
                @(posedge clk); #1;
                if (exp_q.size() == 0) begin
                    check("scoreboard underflow", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({e.tag, " rs_start"}, rs_seen, e.rs);
                    check({e.tag, " locked"}, locked, e.lk);
                    check({e.tag, " quad_sel"}, quad_sel, e.qd);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset quad_sel", quad_sel, 0);
        check("R1 reset locked", locked, 0);
        check("R1 reset rs_start", rs_start, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        // R2: rotation steps and wraps
        for (int i = 0; i < 4 * DWELL; i++) send(1'b0, "R2 search step");
        // R8: hits without byte_vld are ignored
        idle(5, 1'b1);
        @(posedge clk); #1;
        check("R8 idle hit locked", locked, 0);
        check("R8 idle hit quad_sel", quad_sel, 0);
        // partial dwell then R8 idle, then hit on last dwell byte (R3 wins)
        for (int i = 0; i < DWELL - 1; i++) send(1'b0, "R2 partial dwell");
        idle(3, 1'b1);
        send(1'b1, "R3 hit on last dwell byte");
        // R4/R5: block with planted hits, R6 confirm
        block_bytes(BLOCK_LEN, "R5 block with hits");
        for (int i = 0; i < MARKER_LEN; i++) send(i == MARKER_LEN - 1, "R6 marker confirm");
        block_bytes(BLOCK_LEN, "R4 second block");
        // R7: missing marker
        for (int i = 0; i < MARKER_LEN; i++) send(1'b0, "R7 marker missing");
        for (int i = 0; i < DWELL + 2; i++) send(1'b0, "R7 fresh dwell");
        // early hit in verify window is not the confirming byte
        send(1'b1, "R3 relock");
        block_bytes(BLOCK_LEN, "R5 third block");
        for (int i = 0; i < MARKER_LEN; i++) send(i == 0, "R6 early hit only");
        for (int i = 0; i < 3 * DWELL; i++) send(1'b0, "R2 wrap search");
        @(posedge clk); #2;
        byte_vld = 1'b0; marker_hit = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        check("R4 rs_start idle low", rs_start, 0);
        check("scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule